// File: doc/BRIEF.md
# Safe-Switching Clock Source Selector

This block picks one of three clock sources for each of two storage-card host clock channels. Software writes a 2-bit source code into a channel's field of a shared write port. The block never applies an illegal code. It never moves a channel directly between the two fastest sources. When software asks for such a move, the block first steps through the slowest source and then goes on to the target, without further software action. While a channel is switching, its busy bit stays high, and software polls that bit before it issues the next request.

Each source change is carried out as a request/acknowledge handshake with the glitch-free multiplexer in the clock domain. The block raises `sw_req` for the channel and presents the code on `sw_sel`. The new code counts as applied in the cycle after `sw_ack` is sampled high. A write of the illegal code is refused, and the refusal is recorded in a sticky per-channel error flag that software clears by writing 1 to it.

Each channel runs its own state machine with three states. In `ST_IDLE` no switch is in progress. In `ST_HOP` the channel is moving to the slowest source on the way to its target. In `ST_FINAL` the channel is moving to the requested target. The transitions are as follows:

- `IDLE->HOP` on an accepted request that is a forbidden direct move.
- `IDLE->FINAL` on any other accepted request that is legal and different from the current code.
- `HOP->FINAL` on acknowledge.
- `FINAL->IDLE` on acknowledge.

Top module: `safe_clksel`

## Requirements
- R1: After reset, every channel's applied code is 1 (fastest source), busy is 0, the error flag is 0, and no switch request is raised.
- R2: A write with `wr_addr`=0 updates channel c only when both enable bits [17+4c:16+4c] are 1. The new code is taken from bits [1+4c:4c]. When the enable bits are not both set, the field is left unchanged and no switch starts.
- R3: A legal request from an idle channel performs exactly one handshake whose `sw_sel` is the target code. Legal requests are those to or from code 3, and the code must differ from the current one.
- R4: A request between codes 1 and 2, in either direction, performs two handshakes. The first is to code 3, and the applied code reads 3 in between. The second is to the target. The applied code never moves directly between 1 and 2.
- R5: Busy rises in the cycle after an accepted write and stays high until the cycle after the last acknowledge. The applied code changes only in the cycle after an acknowledge.
- R6: A write of code 0 to an idle channel leaves the applied code unchanged, starts no switch, and sets that channel's error flag. The applied code is never 0.
- R7: The error flag is sticky. A write with `wr_addr`=1 clears the flag of channel c only when data bit c and its enable bit 16+c are both 1.
- R8: Writes to a channel while its busy bit is high are ignored, and the switch in progress completes to its original target.
- R9: The channels are independent. One write can start both channels, and each channel follows its own path and keeps its own flags.
- R10: A request for the code already applied starts no switch, and busy stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0: source select register, 1: error-clear register |
| wr_data | input | 32 | Write word: enable bits in [31:16], values in [15:0] |
| sw_ack | input | NUM_CH | Per-channel acknowledge from the clock multiplexer |
| sw_req | output | NUM_CH | Per-channel switch request |
| sw_sel | output | 2*NUM_CH | Code requested from the multiplexer, 2 bits per channel |
| cur_sel | output | 2*NUM_CH | Currently applied code, 2 bits per channel |
| busy | output | NUM_CH | Per-channel switch-in-progress status |
| err_flag | output | NUM_CH | Per-channel sticky refused-write flag |

## Verification
The in-RTL assertions check the following on every cycle:

- The applied code is never 0.
- It never steps directly between codes 1 and 2.
- It moves only after an acknowledge.
- Busy cannot drop without an acknowledge.
- The error flag cannot fall without a clear.
- A raised request never carries code 0.

Some behaviours can only be shown by the bench's scenarios. These are the exact sequence of codes handed to the multiplexer for each kind of request, the intermediate code being visible between the two steps, writes being refused during busy or without enable bits, same-code requests, and two channels switching at once. The bench checks these against a per-channel queue of expected handshakes.

// File: rtl/safe_clksel_pkg.sv
package safe_clksel_pkg;

    localparam int unsigned CODE_W = 2;

    localparam logic [CODE_W-1:0] SRC_BAD  = 2'd0;
    localparam logic [CODE_W-1:0] SRC_FAST = 2'd1;
    localparam logic [CODE_W-1:0] SRC_MID  = 2'd2;
    localparam logic [CODE_W-1:0] SRC_SLOW = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOP   = 2'd1,
        ST_FINAL = 2'd2
    } sw_state_e;

endpackage

// File: rtl/safe_clksel_wdec.sv
module safe_clksel_wdec
    import safe_clksel_pkg::*;
#(
    parameter int unsigned NUM_CH       = 2,
    parameter int unsigned DATA_W       = 32,
    parameter int unsigned FIELD_STRIDE = 4
) (
    input  logic                       wr_en,
    input  logic                       wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    output logic [NUM_CH-1:0]          sel_wr,
    output logic [NUM_CH*CODE_W-1:0]   sel_val,
    output logic [NUM_CH-1:0]          err_clr
);

    localparam int unsigned EN_OFS = DATA_W / 2;

    // Reduction keeps every data bit referenced regardless of channel count.
    logic unused_bits;
    assign unused_bits = ^wr_data;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
        assign sel_wr[c] = wr_en && !wr_addr
                           && (&wr_data[EN_OFS + c*FIELD_STRIDE +: CODE_W]);
        assign sel_val[c*CODE_W +: CODE_W] = wr_data[c*FIELD_STRIDE +: CODE_W];
        assign err_clr[c] = wr_en && wr_addr && wr_data[EN_OFS + c] && wr_data[c];
    end

endmodule

// File: rtl/safe_clksel_chan.sv
module safe_clksel_chan
    import safe_clksel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_wr,
    input  logic [CODE_W-1:0] sel_val,
    input  logic              err_clr,
    input  logic              sw_ack,
    output logic              sw_req,
    output logic [CODE_W-1:0] sw_sel,
    output logic [CODE_W-1:0] cur_sel,
    output logic              busy,
    output logic              err_flag
);

    sw_state_e         state_q, state_d;
    logic [CODE_W-1:0] tgt_q;
    logic [CODE_W-1:0] cur_q;
    logic              err_q;

    logic accept, is_zero, is_same, forbidden, start;

    assign accept    = sel_wr && (state_q == ST_IDLE);
    assign is_zero   = (sel_val == SRC_BAD);
    assign is_same   = (sel_val == cur_q);
    assign forbidden = ((cur_q == SRC_FAST) && (sel_val == SRC_MID))
                    || ((cur_q == SRC_MID)  && (sel_val == SRC_FAST));
    assign start     = accept && !is_zero && !is_same;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)  state_d = forbidden ? ST_HOP : ST_FINAL;
            ST_HOP:   if (sw_ack) state_d = ST_FINAL;
            ST_FINAL: if (sw_ack) state_d = ST_IDLE;
            default:              state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Target, applied code and error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q <= SRC_FAST;
            cur_q <= SRC_FAST;
            err_q <= 1'b0;
        end else begin
            if (start) tgt_q <= sel_val;
            if (state_q == ST_HOP && sw_ack)        cur_q <= SRC_SLOW;
            else if (state_q == ST_FINAL && sw_ack) cur_q <= tgt_q;
            if (accept && is_zero) err_q <= 1'b1;
            else if (err_clr)      err_q <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        sw_req = 1'b0;
        sw_sel = cur_q;
        unique case (state_q)
            ST_IDLE:  begin sw_req = 1'b0; sw_sel = cur_q;    end
            ST_HOP:   begin sw_req = 1'b1; sw_sel = SRC_SLOW; end
            ST_FINAL: begin sw_req = 1'b1; sw_sel = tgt_q;    end
            default:  begin sw_req = 1'b0; sw_sel = cur_q;    end
        endcase
    end

    assign busy     = sw_req;
    assign cur_sel  = cur_q;
    assign err_flag = err_q;

    AST_SEL_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cur_sel != SRC_BAD); // R6
    AST_NO_FAST_TO_MID: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cur_sel) == SRC_FAST) |-> (cur_sel != SRC_MID)); // R4
    AST_NO_MID_TO_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cur_sel) == SRC_MID) |-> (cur_sel != SRC_FAST)); // R4
    AST_MOVE_ONLY_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_sel != $past(cur_sel)) |-> $past(sw_ack)); // R5
    AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && !$past(sw_ack)) |-> busy); // R5
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(err_flag) && !$past(err_clr)) |-> err_flag); // R7
    AST_REQ_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        sw_req |-> (sw_sel != SRC_BAD)); // R3

endmodule

// File: rtl/safe_clksel.sv
module safe_clksel
    import safe_clksel_pkg::*;
#(
    parameter int unsigned NUM_CH       = 2,
    parameter int unsigned DATA_W       = 32,
    parameter int unsigned FIELD_STRIDE = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [NUM_CH-1:0]        sw_ack,
    output logic [NUM_CH-1:0]        sw_req,
    output logic [NUM_CH*CODE_W-1:0] sw_sel,
    output logic [NUM_CH*CODE_W-1:0] cur_sel,
    output logic [NUM_CH-1:0]        busy,
    output logic [NUM_CH-1:0]        err_flag
);

    logic [NUM_CH-1:0]        sel_wr;
    logic [NUM_CH*CODE_W-1:0] sel_val;
    logic [NUM_CH-1:0]        err_clr;

    safe_clksel_wdec #(
        .NUM_CH      (NUM_CH),
        .DATA_W      (DATA_W),
        .FIELD_STRIDE(FIELD_STRIDE)
    ) wdec_i (
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .sel_wr (sel_wr),
        .sel_val(sel_val),
        .err_clr(err_clr)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        safe_clksel_chan chan_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel_wr  (sel_wr[c]),
            .sel_val (sel_val[c*CODE_W +: CODE_W]),
            .err_clr (err_clr[c]),
            .sw_ack  (sw_ack[c]),
            .sw_req  (sw_req[c]),
            .sw_sel  (sw_sel[c*CODE_W +: CODE_W]),
            .cur_sel (cur_sel[c*CODE_W +: CODE_W]),
            .busy    (busy[c]),
            .err_flag(err_flag[c])
        );
    end

endmodule

// File: tb/safe_clksel_tb_top.sv
module safe_clksel_tb_top;

    localparam int ACK_LAT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic [1:0]  sw_ack;
    logic [1:0]  sw_req;
    logic [3:0]  sw_sel;
    logic [3:0]  cur_sel;
    logic [1:0]  busy;
    logic [1:0]  err_flag;

    int n_chk = 0;
    int n_bad = 0;
    logic [1:0] exp_q0[$];
    logic [1:0] exp_q1[$];
    int ack_cnt[2];

    always #4 clk = ~clk; // 125 MHz

    safe_clksel dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sw_ack(sw_ack), .sw_req(sw_req), .sw_sel(sw_sel),
        .cur_sel(cur_sel), .busy(busy), .err_flag(err_flag)
    );

    // Clock-domain model: acknowledge after ACK_LAT cycles of request
    always @(posedge clk) begin
        for (int c = 0; c < 2; c++) begin
            if (!rst_n) begin
                sw_ack[c]  <= 1'b0;
                ack_cnt[c] <= 0;
            end else if (sw_ack[c]) begin
                sw_ack[c]  <= 1'b0;
                ack_cnt[c] <= 0;
            end else if (sw_req[c]) begin
                if (ack_cnt[c] == ACK_LAT - 1) sw_ack[c] <= 1'b1;
                else ack_cnt[c] <= ack_cnt[c] + 1;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: each handshake must match the next expected code
    always @(negedge clk) begin
        if (rst_n && sw_ack[0] === 1'b1) begin
            if (exp_q0.size() == 0) chk("R3 ch0 unexpected handshake", int'(sw_sel[1:0]), 9);
            else chk("R3/R4 ch0 handshake code", int'(sw_sel[1:0]), int'(exp_q0.pop_front()));
        end
        if (rst_n && sw_ack[1] === 1'b1) begin
            if (exp_q1.size() == 0) chk("R3 ch1 unexpected handshake", int'(sw_sel[3:2]), 9);
            else chk("R3/R4 ch1 handshake code", int'(sw_sel[3:2]), int'(exp_q1.pop_front()));
        end
    end

    task automatic push(input int ch, input logic [1:0] v);
        if (ch == 0) exp_q0.push_back(v);
        else         exp_q1.push_back(v);
    endtask

    function automatic logic [31:0] selw(input int ch, input logic [1:0] v);
        return (32'h3 << (16 + 4*ch)) | (32'(v) << (4*ch));
    endfunction

    task automatic wr(input logic a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic wait_idle();
        int n = 0;
        do begin @(negedge clk); n++; end while (busy != 2'b00 && n < 200);
    endtask

    task automatic wait_ack0();
        int n = 0;
        while (sw_ack[0] !== 1'b1 && n < 200) begin @(negedge clk); n++; end
        @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset cur0", int'(cur_sel[1:0]), 1);
        chk("R1 reset cur1", int'(cur_sel[3:2]), 1);
        chk("R1 reset busy", int'(busy), 0);
        chk("R1 reset err", int'(err_flag), 0);
        chk("R1 reset req", int'(sw_req), 0);

        // R3: 1 -> 3 direct
        push(0, 2'd3);
        wr(1'b0, selw(0, 2'd3));
        chk("R5 busy after accepted write", int'(busy[0]), 1);
        wait_idle();
        chk("R3 cur0 after 1->3", int'(cur_sel[1:0]), 3);

        // R3: 3 -> 2 direct
        push(0, 2'd2);
        wr(1'b0, selw(0, 2'd2));
        wait_idle();
        chk("R3 cur0 after 3->2", int'(cur_sel[1:0]), 2);

        // R4: 2 -> 1 via 3
        push(0, 2'd3); push(0, 2'd1);
        wr(1'b0, selw(0, 2'd1));
        wait_ack0();
        chk("R4 intermediate cur0", int'(cur_sel[1:0]), 3);
        chk("R5 busy across hop", int'(busy[0]), 1);
        wait_idle();
        chk("R4 cur0 after 2->1", int'(cur_sel[1:0]), 1);

        // R4: 1 -> 2 via 3
        push(0, 2'd3); push(0, 2'd2);
        wr(1'b0, selw(0, 2'd2));
        wait_idle();
        chk("R4 cur0 after 1->2", int'(cur_sel[1:0]), 2);

        // R2: only one enable bit set -> no effect
        wr(1'b0, 32'h0001_0003);
        repeat (3) @(negedge clk);
        chk("R2 partial enable busy", int'(busy[0]), 0);
        chk("R2 partial enable cur0", int'(cur_sel[1:0]), 2);

        // R10: same code
        wr(1'b0, selw(0, 2'd2));
        chk("R10 same code busy", int'(busy[0]), 0);
        repeat (6) @(negedge clk);
        chk("R10 same code cur0", int'(cur_sel[1:0]), 2);

        // R6: code 0 refused
        wr(1'b0, selw(0, 2'd0));
        chk("R6 zero busy", int'(busy[0]), 0);
        chk("R6 zero cur0", int'(cur_sel[1:0]), 2);
        chk("R6 zero err0", int'(err_flag[0]), 1);
        chk("R6 zero err1 untouched", int'(err_flag[1]), 0);

        // R7: clear without enable keeps flag; with enable clears
        wr(1'b1, 32'h0000_0001);
        chk("R7 clear without enable", int'(err_flag[0]), 1);
        wr(1'b1, 32'h0001_0001);
        chk("R7 clear with enable", int'(err_flag[0]), 0);

        // R8: write while busy ignored
        push(0, 2'd3);
        wr(1'b0, selw(0, 2'd3));
        wr(1'b0, selw(0, 2'd1));
        wait_idle();
        chk("R8 cur0 kept original target", int'(cur_sel[1:0]), 3);
        repeat (8) @(negedge clk);
        chk("R8 no late switch", int'(busy[0]), 0);

        // R9: both channels at once, ch1 field at bits 5:4
        push(0, 2'd1);
        push(1, 2'd3); push(1, 2'd2);
        wr(1'b0, selw(0, 2'd1) | selw(1, 2'd2));
        chk("R9 both busy", int'(busy), 3);
        wait_idle();
        chk("R9 cur0", int'(cur_sel[1:0]), 1);
        chk("R9 cur1", int'(cur_sel[3:2]), 2);

        // R9/R6: zero on ch1 only
        wr(1'b0, selw(1, 2'd0));
        chk("R9 err flags", int'(err_flag), 2);
        chk("R6 cur1 kept", int'(cur_sel[3:2]), 2);

        repeat (4) @(negedge clk);
        chk("R3 ch0 queue drained", exp_q0.size(), 0);
        chk("R4 ch1 queue drained", exp_q1.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule